// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block records a stream of narrow samples into a circular store and freezes the store around a trigger event. Samples arrive on a data bus with a one-cycle valid strobe. They may come only once every few clocks. The block is configured and read entirely through a Wishbone classic slave port with single-cycle acknowledge.

Software first programs three settings: a threshold amplitude, a threshold duration and a post-trigger run length. It then arms the block through the control register. While armed, each valid sample is stored at the write pointer. The trigger fires once the sample value has stayed above the threshold for the programmed number of consecutive samples. After the trigger the block stores the programmed number of further samples and then freezes. Software polls the status flag and reads the store length. It then reads the frozen window oldest-first through a memory-mapped aperture, which is remapped through the frozen write pointer.

Top module: `trig_capture_ctrl`

## Requirements
- R1: A bus request (cyc and stb high, ack low) is acknowledged on the next clock edge with a single-cycle ack. Read data is valid in the same cycle as ack, and a write takes effect at the request edge.
- R2: Writing a value with bit 0 set to word address 0 arms the block. Arming clears the triggered flag, the consecutive-sample count and the post-trigger count, sets the write pointer to 0 and starts capture. Address 0 reads 1 in bit 0 while capture runs and 0 otherwise. A write with bit 0 clear has no effect.
- R3: While capture runs, every valid sample is stored at the write pointer, and the pointer advances modulo the store depth. A sample that arrives while idle or frozen is not stored, and a sample that arrives in the same cycle as an arm write is dropped.
- R4: Before the trigger, each stored sample greater than the threshold (address 2 holds the run length, address 3 holds the threshold, address 4 holds the duration) increments a consecutive count, and any other sample resets the count to 0. The trigger fires on the sample that brings the count to at least the duration. A duration of 0 behaves like 1.
- R5: Once fired, the trigger stays latched until the next arm write, and it reads as bit 0 of word address 1.
- R6: With a run length of N, capture freezes after N further valid samples following the trigger sample. With N = 0 it freezes on the trigger sample itself.
- R7: Word address 0x100 reads the store depth (32 by default).
- R8: Word address 0x800 + i reads the i-th oldest entry of the window. For run length N, entry DEPTH-1-N holds the trigger sample.
- R9: Writes to addresses 1, 0x100 and the store aperture change nothing. Any address that is not mapped reads 0.
- R10: Addresses 2, 3 and 4 read back the last value written to them, 16, 10 and 16 bits wide respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 10 | Sample value |
| smp_valid | input | 1 | One-cycle strobe marking a sample |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 12 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
Ack and read data are due exactly one edge after a request is seen. A register write or an arm is visible to any read issued after that ack. A sample changes the store, the counters and the flags at the edge where its strobe is sampled, so it is visible to the next bus read. The bench drives all inputs on the falling edge and runs a behavioural model on the rising edge from the same inputs. On every falling edge it compares ack, and read data when ack is high, so each result is checked in the cycle it is due. Directed reads then check trigger position, freeze point and window order against sample indices that the bench derives from the waveform it generates.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_POST   = 2'd2,
      ST_FROZEN = 2'd3
   } tcc_state_e;

   localparam int REG_CTRL   = 0;
   localparam int REG_STATUS = 1;
   localparam int REG_RUNLEN = 2;
   localparam int REG_THRESH = 3;
   localparam int REG_DUR    = 4;

endpackage

// File: rtl/tcc_trigger.sv
module tcc_trigger #(
   parameter int SMP_W = 10,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             eval,
   input  logic [SMP_W-1:0] sample,
   input  logic [SMP_W-1:0] thresh,
   input  logic [CNT_W-1:0] dur,
   output logic             fire,
   output logic             triggered
);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_next;
   logic             above;

   assign above    = sample > thresh;
   assign run_next = (run_q == {CNT_W{1'b1}}) ? run_q : run_q + 1'b1;
   assign fire     = eval && above && (run_next >= dur);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         run_q     <= '0;
         triggered <= 1'b0;
      end else begin
         if (eval) begin
            run_q <= above ? run_next : '0;
         end
         if (fire) begin
            triggered <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tcc_sequencer.sv
module tcc_sequencer
   import tcc_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CNT_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             smp_valid,
   input  logic             fire,
   input  logic [CNT_W-1:0] run_len,
   output tcc_state_e       state,
   output logic             capturing,
   output logic             eval,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_ptr
);

   logic [CNT_W-1:0] remain_q;

   assign capturing = (state == ST_ARMED) || (state == ST_POST);
   assign wr_en     = smp_valid && capturing && !arm;
   assign eval      = wr_en && (state == ST_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wr_ptr   <= '0;
         remain_q <= '0;
      end else if (arm) begin
         state    <= ST_ARMED;
         wr_ptr   <= '0;
         remain_q <= '0;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (state == ST_ARMED) begin
            if (fire) begin
               if (run_len == '0) begin
                  state <= ST_FROZEN;
               end else begin
                  state    <= ST_POST;
                  remain_q <= run_len;
               end
            end
         end else begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
               state <= ST_FROZEN;
            end
         end
      end
   end

endmodule

// File: rtl/tcc_ringbuf.sv
module tcc_ringbuf #(
   parameter int DEPTH = 32,
   parameter int SMP_W = 10,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [SMP_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [SMP_W-1:0] rdata
);

   logic [SMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
   import tcc_pkg::*;
#(
   parameter int          DEPTH    = 32,
   parameter int          SMP_W    = 10,
   parameter int          CNT_W    = 16,
   parameter int          ADR_W    = 12,
   parameter int          DAT_W    = 32,
   parameter logic [11:0] LEN_ADDR = 12'h100,
   parameter logic [11:0] BUF_BASE = 12'h800,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc,
   input  logic             stb,
   input  logic             we,
   input  logic [ADR_W-1:0] adr,
   input  logic [DAT_W-1:0] dat_i,
   input  logic             capturing,
   input  logic             triggered,
   input  logic [SMP_W-1:0] buf_rdata,
   output logic [IDX_W-1:0] buf_idx,
   output logic             ack,
   output logic [DAT_W-1:0] dat_o,
   output logic             arm,
   output logic [CNT_W-1:0] run_len,
   output logic [SMP_W-1:0] thresh,
   output logic [CNT_W-1:0] dur
);

   localparam logic [ADR_W-1:0] BASE_V = ADR_W'(BUF_BASE);
   localparam logic [ADR_W-1:0] LEN_V  = ADR_W'(LEN_ADDR);

   logic             req;
   logic             wr;
   logic             buf_hit;
   logic [DAT_W-1:0] rd_mux;
   logic             unused_hi;

   assign req     = cyc && stb && !ack;
   assign wr      = req && we;
   assign arm     = wr && (adr == ADR_W'(REG_CTRL)) && dat_i[0];
   assign buf_hit = adr[ADR_W-1:IDX_W] == BASE_V[ADR_W-1:IDX_W];
   assign buf_idx = adr[IDX_W-1:0];
   assign unused_hi = ^dat_i[DAT_W-1:CNT_W];

   always_comb begin
      rd_mux = '0;
      if (buf_hit) begin
         rd_mux = DAT_W'(buf_rdata);
      end else if (adr == LEN_V) begin
         rd_mux = DAT_W'(DEPTH);
      end else begin
         case (adr)
            ADR_W'(REG_CTRL):   rd_mux = DAT_W'(capturing);
            ADR_W'(REG_STATUS): rd_mux = DAT_W'(triggered);
            ADR_W'(REG_RUNLEN): rd_mux = DAT_W'(run_len);
            ADR_W'(REG_THRESH): rd_mux = DAT_W'(thresh);
            ADR_W'(REG_DUR):    rd_mux = DAT_W'(dur);
            default:            rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack     <= 1'b0;
         dat_o   <= '0;
         run_len <= '0;
         thresh  <= '0;
         dur     <= '0;
      end else begin
         ack <= req;
         if (req) begin
            dat_o <= rd_mux;
         end
         if (wr) begin
            case (adr)
               ADR_W'(REG_RUNLEN): run_len <= dat_i[CNT_W-1:0];
               ADR_W'(REG_THRESH): thresh  <= dat_i[SMP_W-1:0];
               ADR_W'(REG_DUR):    dur     <= dat_i[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
   import tcc_pkg::*;
#(
   parameter int          DEPTH    = 32,
   parameter int          SMP_W    = 10,
   parameter int          CNT_W    = 16,
   parameter int          ADR_W    = 12,
   parameter int          DAT_W    = 32,
   parameter logic [11:0] LEN_ADDR = 12'h100,
   parameter logic [11:0] BUF_BASE = 12'h800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             smp_valid,
   input  logic             wb_cyc_i,
   input  logic             wb_stb_i,
   input  logic             wb_we_i,
   input  logic [ADR_W-1:0] wb_adr_i,
   input  logic [DAT_W-1:0] wb_dat_i,
   output logic [DAT_W-1:0] wb_dat_o,
   output logic             wb_ack_o
);

   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if ((int'(BUF_BASE) % DEPTH) != 0 || int'(BUF_BASE) + DEPTH > (1 << ADR_W)) begin : g_bad_base
         $error("store aperture must be aligned to DEPTH and fit the address range");
      end
      if (int'(LEN_ADDR) <= REG_DUR || int'(LEN_ADDR) >= (1 << ADR_W) ||
          (int'(LEN_ADDR) >= int'(BUF_BASE) && int'(LEN_ADDR) < int'(BUF_BASE) + DEPTH)) begin : g_bad_len
         $error("length address collides with another register");
      end
      if (DAT_W < SMP_W || DAT_W < CNT_W || CNT_W < IDX_W + 1) begin : g_bad_width
         $error("data bus must hold a sample and a count");
      end
   endgenerate

   logic             arm;
   logic [CNT_W-1:0] run_len;
   logic [SMP_W-1:0] thresh;
   logic [CNT_W-1:0] dur;
   logic             fire;
   logic             triggered;
   logic             capturing;
   logic             eval;
   logic             wr_en;
   logic [IDX_W-1:0] wr_ptr;
   logic [IDX_W-1:0] buf_idx;
   logic [SMP_W-1:0] buf_rdata;
   tcc_state_e       seq_state;

   tcc_regs #(
      .DEPTH(DEPTH), .SMP_W(SMP_W), .CNT_W(CNT_W), .ADR_W(ADR_W),
      .DAT_W(DAT_W), .LEN_ADDR(LEN_ADDR), .BUF_BASE(BUF_BASE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
      .adr(wb_adr_i), .dat_i(wb_dat_i),
      .capturing(capturing), .triggered(triggered),
      .buf_rdata(buf_rdata), .buf_idx(buf_idx),
      .ack(wb_ack_o), .dat_o(wb_dat_o),
      .arm(arm), .run_len(run_len), .thresh(thresh), .dur(dur)
   );

   tcc_trigger #(.SMP_W(SMP_W), .CNT_W(CNT_W)) trig_i (
      .clk(clk), .rst_n(rst_n), .clear(arm), .eval(eval),
      .sample(smp_data), .thresh(thresh), .dur(dur),
      .fire(fire), .triggered(triggered)
   );

   tcc_sequencer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
      .fire(fire), .run_len(run_len),
      .state(seq_state), .capturing(capturing), .eval(eval),
      .wr_en(wr_en), .wr_ptr(wr_ptr)
   );

   tcc_ringbuf #(.DEPTH(DEPTH), .SMP_W(SMP_W)) buf_i (
      .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(smp_data),
      .raddr(wr_ptr + buf_idx), .rdata(buf_rdata)
   );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker
   import tcc_pkg::*;
#(
   parameter int          DEPTH    = 32,
   parameter int          ADR_W    = 12,
   parameter int          DAT_W    = 32,
   parameter logic [11:0] LEN_ADDR = 12'h100,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc,
   input logic             stb,
   input logic             we,
   input logic [ADR_W-1:0] adr,
   input logic             ack,
   input logic [DAT_W-1:0] dat_o,
   input tcc_state_e       state,
   input logic             triggered,
   input logic             arm,
   input logic [IDX_W-1:0] wr_ptr
);

   // R1: ack is a single pulse and only answers a request
   p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   p_ack_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(cyc && stb));

   // R2: arming clears the trigger and restarts capture
   p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!triggered && state == ST_ARMED));

   // R3: a frozen store keeps its write pointer
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FROZEN && !arm) |=> $stable(wr_ptr));

   // R5: trigger flag latches until re-armed
   p_trig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> triggered);

   // R6: freezing only follows a trigger
   p_frozen_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FROZEN) |-> triggered);

   // R7: length read returns the depth
   p_len_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(cyc && stb && !we && adr == ADR_W'(LEN_ADDR))) |-> dat_o == DAT_W'(DEPTH));

endmodule

bind trig_capture_ctrl tcc_checker #(
   .DEPTH(DEPTH), .ADR_W(ADR_W), .DAT_W(DAT_W), .LEN_ADDR(LEN_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
   .adr(wb_adr_i), .ack(wb_ack_o), .dat_o(wb_dat_o), .state(seq_state),
   .triggered(triggered), .arm(arm), .wr_ptr(wr_ptr)
);

// File: tb/trig_capture_ctrl_tb_top.sv
module trig_capture_ctrl_tb_top;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  smp_data = '0;
   logic        smp_valid = 1'b0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [11:0] adr = '0;
   logic [31:0] dat_i = '0;
   logic [31:0] dat_o;
   logic        ack;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   trig_capture_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
      .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_mem [DEPTH];
   int m_ptr, m_state, m_cnt, m_rem, m_run, m_thr, m_dur;
   bit m_trig, m_ack;
   int m_dat;

   function automatic int model_read(input int a);
      if (a >= 'h800 && a < 'h800 + DEPTH) return m_mem[(m_ptr + a - 'h800) % DEPTH];
      case (a)
         0:      return (m_state == 1 || m_state == 2) ? 1 : 0;
         1:      return int'(m_trig);
         2:      return m_run;
         3:      return m_thr;
         4:      return m_dur;
         'h100:  return DEPTH;
         default: return 0;
      endcase
   endfunction

   initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ptr = 0; m_state = 0; m_cnt = 0; m_rem = 0;
         m_run = 0; m_thr = 0; m_dur = 0; m_trig = 0; m_ack = 0; m_dat = 0;
      end else begin
         bit req, armw;
         req  = cyc && stb && !m_ack;
         armw = req && we && adr == 0 && dat_i[0];
         if (req) m_dat = model_read(int'(adr));
         if (req && we) begin
            if (adr == 2) m_run = int'(dat_i[15:0]);
            if (adr == 3) m_thr = int'(dat_i[9:0]);
            if (adr == 4) m_dur = int'(dat_i[15:0]);
         end
         if (armw) begin
            m_state = 1; m_ptr = 0; m_trig = 0; m_cnt = 0; m_rem = 0;
         end else if (smp_valid && (m_state == 1 || m_state == 2)) begin
            m_mem[m_ptr] = int'(smp_data);
            m_ptr = (m_ptr + 1) % DEPTH;
            if (m_state == 1) begin
               if (int'(smp_data) > m_thr) m_cnt++; else m_cnt = 0;
               if (int'(smp_data) > m_thr && m_cnt >= m_dur) begin
                  m_trig = 1;
                  if (m_run == 0) m_state = 3;
                  else begin m_state = 2; m_rem = m_run; end
               end
            end else begin
               m_rem--;
               if (m_rem == 0) m_state = 3;
            end
         end
         m_ack = req;
      end
   end

   // compare on every clock, away from the active edge (R1, R8 via model)
   always @(negedge clk) begin
      if (rst_n) begin
         chk(ack == m_ack, "R1 ack", int'(ack), int'(m_ack));
         if (ack && m_ack) chk(int'(dat_o) == m_dat, "R1 read data", int'(dat_o), m_dat);
      end
   end

   // ---------------- stimulus ----------------
   function automatic int wave(input int k);
      if (k >= 40 && k < 45) return 900;
      if (k < 70) return 100 + 3 * k;
      return 850 + (k - 70);
   endfunction

   task automatic wb_write(input int a, input int d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = 12'(a); dat_i = 32'(d);
      do @(negedge clk); while (!ack);
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic wb_read(input int a, output int d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 12'(a);
      do @(negedge clk); while (!ack);
      d = int'(dat_o);
      cyc = 0; stb = 0;
   endtask

   task automatic feed(input int v);
      @(negedge clk);
      smp_valid = 1; smp_data = 10'(v);
      @(negedge clk);
      smp_valid = 0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int d;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(ack == 1'b0, "R1 reset ack", int'(ack), 0);
      wb_read(1, d); chk(d == 0, "R5 reset status", d, 0);
      wb_read(0, d); chk(d == 0, "R2 reset idle", d, 0);

      // configuration and readback
      wb_write(2, 0); wb_write(3, 800); wb_write(4, 10);
      wb_read(3, d); chk(d == 800, "R10 thresh", d, 800);
      wb_read(4, d); chk(d == 10, "R10 dur", d, 10);
      wb_write(2, 32'h0001_0007);
      wb_read(2, d); chk(d == 7, "R10 run len width", d, 7);
      wb_write(2, 0);
      wb_read('h100, d); chk(d == DEPTH, "R7 length", d, DEPTH);
      wb_write(1, 1); wb_write('h100, 5);
      wb_read(1, d); chk(d == 0, "R9 status write ignored", d, 0);
      wb_read('h100, d); chk(d == DEPTH, "R9 length write ignored", d, DEPTH);
      wb_read('h200, d); chk(d == 0, "R9 unmapped", d, 0);

      // samples before arming are not stored
      feed(1000); feed(1000);
      wb_read(1, d); chk(d == 0, "R3 idle samples ignored", d, 0);

      // run 1: run length 0
      wb_write(0, 1);
      wb_read(0, d); chk(d == 1, "R2 capturing", d, 1);
      for (int k = 0; k < 79; k++) feed(wave(k));
      wb_read(1, d); chk(d == 0, "R4 short burst no trigger", d, 0);
      feed(wave(79));
      wb_read(1, d); chk(d == 1, "R5 triggered", d, 1);
      wb_read(0, d); chk(d == 0, "R6 frozen at trigger", d, 0);
      for (int i = 0; i < DEPTH; i++) begin
         wb_read('h800 + i, d);
         chk(d == wave(48 + i), "R8 window run0", d, wave(48 + i));
      end
      feed(5); feed(6);
      wb_read('h800 + DEPTH - 1, d); chk(d == wave(79), "R3 frozen samples ignored", d, wave(79));
      wb_write('h800, 3);
      wb_read('h800, d); chk(d == wave(48), "R9 store write ignored", d, wave(48));
      wb_write(0, 0);
      wb_read(1, d); chk(d == 1, "R2 write zero no effect", d, 1);
      wb_read(0, d); chk(d == 0, "R2 write zero stays frozen", d, 0);

      // run 2: run length 16
      wb_write(2, 16);
      wb_write(0, 1);
      wb_read(1, d); chk(d == 0, "R2 rearm clears trigger", d, 0);
      for (int k = 0; k < 95; k++) feed(wave(k));
      wb_read(1, d); chk(d == 1, "R5 triggered run16", d, 1);
      wb_read(0, d); chk(d == 1, "R6 still capturing", d, 1);
      feed(wave(95));
      wb_read(0, d); chk(d == 0, "R6 frozen after run", d, 0);
      for (int i = 0; i < DEPTH; i++) begin
         wb_read('h800 + i, d);
         chk(d == wave(64 + i), "R8 window run16", d, wave(64 + i));
      end
      wb_read('h800 + DEPTH - 1 - 16, d); chk(d == wave(79), "R8 trigger slot", d, wave(79));

      // run 3: duration 0 fires on first high sample
      wb_write(2, 0); wb_write(4, 0);
      wb_write(0, 1);
      feed(wave(68)); feed(wave(69));
      wb_read(1, d); chk(d == 0, "R4 low samples no trigger", d, 0);
      feed(wave(70));
      wb_read(1, d); chk(d == 1, "R4 dur zero trigger", d, 1);
      wb_read('h800 + DEPTH - 1, d); chk(d == wave(70), "R8 newest dur0", d, wave(70));
      wb_read('h800 + DEPTH - 3, d); chk(d == wave(68), "R3 ptr reset on arm", d, wave(68));

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule